// File: doc/BRIEF.md
# Serial Clock-Configuration Write Slave

This block is a write-only, two-wire serial slave that holds the configuration of a clock generator. It runs entirely on a fast system clock. It oversamples the serial clock and data lines and finds start and stop conditions on them. It shifts in bytes with the most significant bit first and pulls the data line low to acknowledge. Each write burst is eleven bytes long. The first is the device address with the write bit, which is fixed at `8'hD2`. Two header bytes follow, which are acknowledged but whose values are thrown away. The last eight are data bytes, and they land in eight 8-bit control registers.

The registers load fixed defaults at reset, so the clock generator runs correctly if software never writes them. All 64 register bits are presented in parallel. Register 0 is also decoded into three things: the frequency-select code, the choice between the strap pins and the register as the source of that code, and the two-bit operating mode with its spread and output-float flags.

Top module: `serclk_cfg_slave`

## Requirements
- R1: Only an address byte equal to `8'hD2` (seven address bits, then a write bit of 0) is acknowledged. Any other address leaves every register unchanged, and no later byte of that transfer is acknowledged.
- R2: Bytes after the address arrive in a fixed order: two header bytes, then data bytes 0 to 7. Data byte k is written to register k, which appears on `cfgRegs[8k+7:8k]`.
- R3: The two header bytes are acknowledged. Their values have no effect on any register or output.
- R4: Each byte is taken most significant bit first. The first bit sampled after the start, or after an acknowledge, becomes bit 7.
- R5: Reset values are: register 1 = `8'h0B`, register 2 = `8'h5F`, register 3 = `8'h37`, register 5 = `8'h13`, and 0 for all other registers. Together, `cfgRegs` = `64'h0000_1300_375F_0B00`.
- R6: Register 0 bits [1:0] appear on `opMode`. The value 2'b10 raises `spreadOn`, 2'b11 raises `outHiZ`, and 2'b00 and 2'b01 raise neither.
- R7: When register 0 bit 3 is 0, `freqSel` follows the `strapSel` input. When it is 1, `freqSel` = {reg0[2], reg0[6], reg0[5], reg0[4]}, most significant bit first.
- R8: A data byte is committed on the rising serial clock of its acknowledge. If a stop condition ends a transfer early, the bytes committed before it are kept and the other registers stay as they were.
- R9: `sdaPullLow` is high during the ninth clock of every byte of an address-matched transfer, up to the eighth data byte. Bytes after the eighth data byte are not acknowledged and change nothing.
- R10: A start condition (data falls while the clock is high) at any point restarts the address phase. A stop condition (data rises while the clock is high) ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line, as seen on the wired bus |
| strapSel | input | 4 | Frequency code taken from the strap pins |
| sdaPullLow | output | 1 | High while the slave pulls the data line low to acknowledge |
| cfgRegs | output | 64 | All eight control registers; register k sits at bits [8k+7:8k] |
| freqSel | output | 4 | Frequency-select code in effect |
| swSelect | output | 1 | 1 when the frequency code comes from register 0 |
| opMode | output | 2 | Operating-mode field |
| spreadOn | output | 1 | Spread modulation requested |
| outHiZ | output | 1 | All clock outputs floated |

## Verification
Two events can meet at the end of a byte: committing it on the acknowledge clock, and ending the transfer with a stop or a repeated start. The bench provokes this in three ways. It stops a burst right after a data byte's acknowledge. It issues a repeated start partway through a header. It overruns the eight data bytes and then stops. In each case it compares every register with a model that keeps exactly the bytes acknowledged before the end of the transfer. The bench also checks that an address-phase restart realigns data byte 0, and that unacknowledged trailing bytes leave the registers alone.

// File: rtl/serclk_cfg_pkg.sv
package serclk_cfg_pkg;

  localparam int CFG_BYTES = 8;
  localparam int CFG_IDX_W = $clog2(CFG_BYTES);

  // control -> datapath strobes
  typedef struct packed {
    logic                 shiftEn;
    logic                 commitEn;
    logic [CFG_IDX_W-1:0] commitIdx;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BITS,
    ST_ACK,
    ST_SKIP
  } busState_t;

  // power-up contents of each control register
  function automatic logic [7:0] resetValue(int idx);
    case (idx)
      1:       return 8'h0B;
      2:       return 8'h5F;
      3:       return 8'h37;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/serclk_line_sync.sv
module serclk_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/serclk_cfg_ctrl.sv
module serclk_cfg_ctrl
  import serclk_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'hD2,
  parameter int         HDR_BYTES = 3,
  parameter int         NUM_BYTES = CFG_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [7:0] shiftByte,
  output cfgStrobe_t strobe,
  output logic       ackLow
);

  localparam int TOTAL = HDR_BYTES + NUM_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);

  busState_t        state;
  logic [3:0]       bitCnt;
  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] dataOff;
  logic             willAck;
  logic             inData;

  // address byte acks on match; later bytes ack until the burst is full
  always_comb begin
    if (byteIdx == '0) willAck = (shiftByte == DEV_ADDR);
    else               willAck = (byteIdx < CNT_W'(TOTAL));
  end

  assign dataOff = byteIdx - CNT_W'(HDR_BYTES);
  assign inData  = (byteIdx >= CNT_W'(HDR_BYTES)) && (byteIdx < CNT_W'(TOTAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      ackLow  <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_BITS;
      bitCnt  <= '0;
      byteIdx <= '0;
      ackLow  <= 1'b0;
    end else if (stopSeen) begin
      state   <= ST_IDLE;
      ackLow  <= 1'b0;
    end else begin
      case (state)
        ST_BITS: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            state  <= ST_ACK;
            ackLow <= willAck;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackLow <= 1'b0;
            bitCnt <= '0;
            if (byteIdx == '0 && !ackLow) begin
              state <= ST_SKIP;
            end else begin
              state <= ST_BITS;
              if (byteIdx != CNT_W'(TOTAL)) byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.shiftEn   = (state == ST_BITS) && sclRise && (bitCnt < 4'd8) && !startSeen && !stopSeen;
    strobe.commitEn  = (state == ST_ACK) && sclRise && ackLow && inData;
    strobe.commitIdx = dataOff[CFG_IDX_W-1:0];
  end

  // R9: the acknowledge is only ever raised while the serial clock is low
  a_r9_ack_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackLow) |-> !sclS);

  // R9: once raised, the acknowledge holds until the clock falls or the bus resets
  a_r9_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ackLow && !sclFall && !startSeen && !stopSeen) |=> ackLow);

  // R10: a start always returns the slave to bit 0 of the address byte
  a_r10_start_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    startSeen |=> (state == ST_BITS && bitCnt == 4'd0 && byteIdx == '0));

  // R4: never more than eight data bits per byte
  a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= 4'd8);

endmodule

// File: rtl/serclk_cfg_regbank.sv
module serclk_cfg_regbank
  import serclk_cfg_pkg::*;
#(
  parameter int NUM_BYTES = CFG_BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cfgStrobe_t             strobe,
  input  logic                   sdaS,
  input  logic [3:0]             strapSel,
  output logic [7:0]             shiftByte,
  output logic [NUM_BYTES*8-1:0] cfgRegs,
  output logic [3:0]             freqSel,
  output logic                   swSelect,
  output logic [1:0]             opMode,
  output logic                   spreadOn,
  output logic                   outHiZ
);

  logic [7:0] byteQ [NUM_BYTES];
  logic [7:0] mode0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shiftByte <= '0;
    else if (strobe.shiftEn) shiftByte <= {shiftByte[6:0], sdaS};
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byteQ[g] <= resetValue(g);
      else if (strobe.commitEn && strobe.commitIdx == CFG_IDX_W'(g))
        byteQ[g] <= shiftByte;
    end
    assign cfgRegs[g*8 +: 8] = byteQ[g];
  end

  assign mode0    = byteQ[0];
  assign swSelect = mode0[3];
  assign freqSel  = swSelect ? {mode0[2], mode0[6], mode0[5], mode0[4]} : strapSel;
  assign opMode   = mode0[1:0];
  assign spreadOn = (opMode == 2'b10);
  assign outHiZ   = (opMode == 2'b11);

  // R8: the register bank moves only on a commit strobe
  a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commitEn |=> $stable(cfgRegs));

  // R8: a commit happens while the bus data line carries the acknowledge
  a_r8_commit_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commitEn |-> !sdaS);

endmodule

// File: rtl/serclk_cfg_slave.sv
module serclk_cfg_slave
  import serclk_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         HDR_BYTES   = 3,
  parameter int         NUM_BYTES   = CFG_BYTES,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [3:0]             strapSel,
  output logic                   sdaPullLow,
  output logic [NUM_BYTES*8-1:0] cfgRegs,
  output logic [3:0]             freqSel,
  output logic                   swSelect,
  output logic [1:0]             opMode,
  output logic                   spreadOn,
  output logic                   outHiZ
);

  logic       sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] shiftByte;
  cfgStrobe_t strobe;

  serclk_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  serclk_cfg_ctrl #(
    .DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES), .NUM_BYTES(NUM_BYTES)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .sclS(sclS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .shiftByte(shiftByte),
    .strobe(strobe), .ackLow(sdaPullLow)
  );

  serclk_cfg_regbank #(.NUM_BYTES(NUM_BYTES)) i_bank (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sdaS(sdaS), .strapSel(strapSel),
    .shiftByte(shiftByte), .cfgRegs(cfgRegs), .freqSel(freqSel),
    .swSelect(swSelect), .opMode(opMode), .spreadOn(spreadOn), .outHiZ(outHiZ)
  );

  // R6: spread and float flags are never raised together
  a_r6_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(spreadOn && outHiZ));

endmodule

// File: tb/test_serclk_cfg_slave.sv
module test_serclk_cfg_slave;

  localparam logic [63:0] DEF_REGS = 64'h0000_1300_375F_0B00;
  localparam int          Q        = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclDrv = 1'b1;
  logic        sdaDrv = 1'b1;
  logic        sdaBus;
  logic [3:0]  strap = 4'b1010;
  logic        sdaPullLow;
  logic [63:0] cfgRegs;
  logic [3:0]  freqSel;
  logic        swSelect;
  logic [1:0]  opMode;
  logic        spreadOn;
  logic        outHiZ;

  int          testsRun = 0;
  int          testsFailed = 0;
  logic        finished = 1'b0;
  logic [63:0] expRegs;
  logic [7:0]  payload [10];
  logic        ackSeen [13];

  always #10 clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  serclk_cfg_slave i_serclk_cfg_slave (
    .clk(clk), .rst_n(rst_n), .sclIn(sclDrv), .sdaIn(sdaBus), .strapSel(strap),
    .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs), .freqSel(freqSel),
    .swSelect(swSelect), .opMode(opMode), .spreadOn(spreadOn), .outHiZ(outHiZ)
  );

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ();
      sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1;
    repeat (Q/2) @(negedge clk);
    acked = sdaPullLow;
    repeat (Q/2) @(negedge clk);
    sclDrv = 1'b0; waitQ();
  endtask

  // address, two header bytes, nData payload bytes, stop
  task automatic sendFrame(input logic [7:0] addr, input logic [7:0] cmd,
                           input logic [7:0] cnt, input int nData);
    logic a;
    busStart();
    sendByte(addr, a); ackSeen[0] = a;
    sendByte(cmd, a);  ackSeen[1] = a;
    sendByte(cnt, a);  ackSeen[2] = a;
    for (int k = 0; k < nData; k++) begin
      sendByte(payload[k], a);
      ackSeen[3+k] = a;
    end
    busStop();
    waitQ();
  endtask

  task automatic setExp(input int k, input logic [7:0] v);
    expRegs[k*8 +: 8] = v;
  endtask

  task automatic tReset();
    checkVal("R5 reset registers", cfgRegs, DEF_REGS);
    checkVal("R6 reset mode flags", {62'd0, spreadOn, outHiZ}, 64'd0);
    checkVal("R7 reset freq from straps", {60'd0, freqSel}, {60'd0, strap});
    checkVal("R9 no ack at idle", {63'd0, sdaPullLow}, 64'd0);
    expRegs = DEF_REGS;
  endtask

  task automatic tFullWrite();
    int acks;
    payload[0] = 8'hA5; payload[1] = 8'h3C; payload[2] = 8'h81; payload[3] = 8'h7E;
    payload[4] = 8'h00; payload[5] = 8'hFF; payload[6] = 8'h01; payload[7] = 8'h80;
    sendFrame(8'hD2, 8'hFF, 8'h55, 8);
    acks = 0;
    for (int k = 0; k < 11; k++) if (ackSeen[k]) acks++;
    checkVal("R9 eleven acks on full burst", 64'(acks), 64'd11);
    checkVal("R3 header bytes acked", {62'd0, ackSeen[1], ackSeen[2]}, 64'd3);
    for (int k = 0; k < 8; k++) setExp(k, payload[k]);
    checkVal("R2 R4 data bytes in order, MSB first", cfgRegs, expRegs);
  endtask

  task automatic tBadAddress();
    for (int k = 0; k < 8; k++) payload[k] = 8'h11 * 8'(k + 1);
    sendFrame(8'hD0, 8'h00, 8'h08, 8);
    checkVal("R1 wrong address not acked", {63'd0, ackSeen[0]}, 64'd0);
    checkVal("R1 wrong address no later ack", {63'd0, ackSeen[3]}, 64'd0);
    checkVal("R1 wrong address leaves registers", cfgRegs, expRegs);
    sendFrame(8'hD3, 8'h00, 8'h08, 8);
    checkVal("R1 read-bit address leaves registers", cfgRegs, expRegs);
  endtask

  task automatic tModeDecode();
    payload[0] = 8'h02;
    sendFrame(8'hD2, 8'h12, 8'h34, 1);
    setExp(0, 8'h02);
    checkVal("R6 mode 10 spread", {60'd0, opMode, spreadOn, outHiZ}, {60'd0, 2'b10, 1'b1, 1'b0});
    checkVal("R8 one-byte burst keeps others", cfgRegs, expRegs);
    payload[0] = 8'h03;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h03);
    checkVal("R6 mode 11 float", {60'd0, opMode, spreadOn, outHiZ}, {60'd0, 2'b11, 1'b0, 1'b1});
    payload[0] = 8'h01;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h01);
    checkVal("R6 mode 01 no flag", {60'd0, opMode, spreadOn, outHiZ}, {60'd0, 2'b01, 1'b0, 1'b0});
  endtask

  task automatic tFreqSource();
    payload[0] = 8'h5C;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h5C);
    checkVal("R7 register freq code", {59'd0, swSelect, freqSel}, {59'd0, 1'b1, 4'b1101});
    payload[0] = 8'h08;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h08);
    checkVal("R7 register freq code zero", {59'd0, swSelect, freqSel}, {59'd0, 1'b1, 4'b0000});
    payload[0] = 8'h74;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h74);
    strap = 4'b0101;
    waitQ();
    checkVal("R7 strap freq code", {59'd0, swSelect, freqSel}, {59'd0, 1'b0, 4'b0101});
  endtask

  task automatic tTruncated();
    payload[0] = 8'h11; payload[1] = 8'h22; payload[2] = 8'h33;
    sendFrame(8'hD2, 8'h9A, 8'hBC, 3);
    setExp(0, 8'h11); setExp(1, 8'h22); setExp(2, 8'h33);
    checkVal("R8 stop after third byte", cfgRegs, expRegs);
  endtask

  task automatic tOverrun();
    logic a1, a2;
    for (int k = 0; k < 8; k++) payload[k] = 8'hC0 + 8'(k);
    busStart();
    sendByte(8'hD2, a1);
    sendByte(8'h00, a1);
    sendByte(8'h00, a1);
    for (int k = 0; k < 8; k++) sendByte(payload[k], a1);
    sendByte(8'hEE, a1);
    sendByte(8'hDD, a2);
    busStop();
    waitQ();
    for (int k = 0; k < 8; k++) setExp(k, payload[k]);
    checkVal("R9 bytes past burst not acked", {62'd0, a1, a2}, 64'd0);
    checkVal("R9 bytes past burst ignored", cfgRegs, expRegs);
  endtask

  task automatic tRestart();
    logic a;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h77, a);
    payload[0] = 8'h42;
    sendFrame(8'hD2, 8'h00, 8'h00, 1);
    setExp(0, 8'h42);
    checkVal("R10 repeated start realigns", cfgRegs, expRegs);
    checkVal("R10 ack after restart", {63'd0, ackSeen[0]}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R10: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tFullWrite();
    tBadAddress();
    tModeDecode();
    tFreqSource();
    tTruncated();
    tOverrun();
    tRestart();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule